// File: doc/BRIEF.md
# Headphone Amplifier Control Register Target

This block is a two-wire serial bus target that holds the control settings of a stereo headphone amplifier. SCL and SDA are oversampled on the system clock. The data line is open-drain, so the block never drives it high: it reports a drive-low request on a separate output, which the pad turns into a pull-down. A controller first writes a pointer byte that selects one of eight register slots. It then writes one data byte, or it starts a read that returns the selected slot. The decoded settings leave the block as parallel outputs that steer the analog path: left and right enables, software shutdown, left and right mute, a 5-bit volume code and left and right output high-impedance.

Only four of the eight slots exist: mode, volume/mute, high-impedance and a read-only identification value. Every other slot is refused with a NACK. A thermal-status input appears as a read-only flag inside the mode register. A general-call reset command returns every setting to its power-on value.

The protocol state machine has these states: IDLE, ADDR (shift in the address byte), ADDR_ACK, PTR (shift in the pointer), PTR_ACK, WDATA (shift in the data byte), WDATA_ACK, GCMD (shift in the general-call command), GCMD_ACK, RDATA (shift out a byte), RD_ACK (sample the controller's acknowledge) and WAIT (bus released until STOP). Every state goes to ADDR on a START and to IDLE on a STOP. The other transitions all happen on a falling SCL once a byte is complete:
- ADDR goes to ADDR_ACK.
- ADDR_ACK goes to GCMD for a general call, to RDATA for an accepted read, to PTR for an accepted write, and to WAIT on NACK.
- PTR goes to PTR_ACK. PTR_ACK goes to WDATA if the pointer was accepted and to WAIT if not.
- WDATA goes to WDATA_ACK, which goes to WAIT.
- GCMD goes to GCMD_ACK, which goes to WAIT.
- RDATA goes to RD_ACK. RD_ACK goes back to RDATA when the controller acknowledges. It goes to WAIT as soon as SCL rises with SDA high (a NACK).

Top module: `hpamp_i2c_regs`

## Requirements
- R1: The address byte is acknowledged when its upper seven bits equal 1100000 (DEV_ADDR, default 7'h60). Bit 0 selects the direction: 0 is a write and 1 is a read. Any other address byte except the general call is NACKed.
- R2: In a write, the first byte after the address is the pointer. Only bits 2:0 select the slot; bits 7:3 have no effect on which slot is accessed.
- R3: Slots 1 to 4 exist. A pointer of 0, 5, 6 or 7 is NACKed. No data write ever reaches a slot outside 1 to 3.
- R4: Mode slot (1): bit 7 is the left enable and bit 6 the right enable, both reset to 0. Bit 0 is software shutdown, reset to 0. Bit 1 reads the thermal_i input and ignores writes. Bits 5:2 read 0. The bits drive en_left_o, en_right_o and sw_shutdown_o.
- R5: Volume slot (2): bit 7 is the left mute and bit 6 the right mute, both reset to 1. Bits 5:1 hold the volume code, reset to 0 and driven on volume_o. Bit 0 reads 0.
- R6: High-impedance slot (3): bit 1 is left and bit 0 is right, both reset to 0 and driven on hiz_left_o and hiz_right_o. Bits 7:2 read 0.
- R7: Slot 4 reads ID_VALUE (default 8'hA3). A data byte written to it is NACKed and leaves the value unchanged.
- R8: The general-call address byte 8'h00 is acknowledged. A following command of 8'h06 is acknowledged and returns every setting and the pointer to their power-on values. Any other command is NACKed and changes nothing.
- R9: A read returns the slot chosen by the most recent pointer write. The same byte is sent again after each controller ACK. A controller NACK releases SDA until the next START or STOP. A read address byte is NACKed while the pointer selects a slot that does not exist, and the pointer is 0 after reset.
- R10: The block starts pulling SDA low only while SCL is low.
- R11: A START or STOP that arrives before the eighth bit of a data byte aborts the transfer and leaves every setting unchanged.
- R12: A write stores a single data byte. A second data byte in the same transfer is NACKed and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| thermal_i | input | 1 | Thermal shutdown status, synchronous to clk |
| sda_drive_low_o | output | 1 | 1 requests the pad to pull SDA low |
| en_left_o | output | 1 | Left channel enable |
| en_right_o | output | 1 | Right channel enable |
| sw_shutdown_o | output | 1 | Software shutdown |
| mute_left_o | output | 1 | Left channel mute |
| mute_right_o | output | 1 | Right channel mute |
| volume_o | output | 5 | Volume code |
| hiz_left_o | output | 1 | Left output high-impedance |
| hiz_right_o | output | 1 | Right output high-impedance |

## Verification
The assertions assume that each SCL phase lasts several system clocks, longer than the synchroniser and edge-detection delay. They also assume that SDA changes while SCL is high only to signal START or STOP, and that thermal_i is already synchronous to clk. The stimulus meets these assumptions by holding every SCL quarter period for eight clocks and by changing its own SDA only in the middle of the low phase. It changes SDA while SCL is high only inside its START and STOP sequences. The thermal input is changed only while the bus is idle.

// File: rtl/hpamp_pkg.sv
`timescale 1ns/1ps
package hpamp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_GCMD,
        ST_GCMD_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_WAIT
    } bus_state_t;

    localparam logic [2:0] SLOT_MODE = 3'd1;
    localparam logic [2:0] SLOT_VOL  = 3'd2;
    localparam logic [2:0] SLOT_HIZ  = 3'd3;
    localparam logic [2:0] SLOT_ID   = 3'd4;

    localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
    localparam logic [7:0] GC_RESET_CMD = 8'h06;

    function automatic logic slot_readable(input logic [2:0] s);
        return (s >= SLOT_MODE) && (s <= SLOT_ID);
    endfunction

    function automatic logic slot_writable(input logic [2:0] s);
        return (s >= SLOT_MODE) && (s <= SLOT_HIZ);
    endfunction

endpackage

// File: rtl/hpamp_sync_edge.sv
`timescale 1ns/1ps
module hpamp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] last;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= '1;
        else        last <= synced;
    end

    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~last[0];
    assign scl_fall = ~synced[0] & last[0];
    assign start_ev = synced[0] & last[0] & last[1] & ~synced[1];
    assign stop_ev  = synced[0] & last[0] & ~last[1] & synced[1];
endmodule

// File: rtl/hpamp_ctrl_regs.sv
`timescale 1ns/1ps
module hpamp_ctrl_regs
    import hpamp_pkg::*;
#(
    parameter logic [7:0] ID_VALUE = 8'hA3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       wr_stb,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_idx,
    input  logic       thermal_i,
    output logic [7:0] rd_data,
    output logic       en_left_o,
    output logic       en_right_o,
    output logic       sw_shutdown_o,
    output logic       mute_left_o,
    output logic       mute_right_o,
    output logic [4:0] volume_o,
    output logic       hiz_left_o,
    output logic       hiz_right_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_left_o     <= 1'b0;
            en_right_o    <= 1'b0;
            sw_shutdown_o <= 1'b0;
            mute_left_o   <= 1'b1;
            mute_right_o  <= 1'b1;
            volume_o      <= '0;
            hiz_left_o    <= 1'b0;
            hiz_right_o   <= 1'b0;
        end else if (soft_rst) begin
            en_left_o     <= 1'b0;
            en_right_o    <= 1'b0;
            sw_shutdown_o <= 1'b0;
            mute_left_o   <= 1'b1;
            mute_right_o  <= 1'b1;
            volume_o      <= '0;
            hiz_left_o    <= 1'b0;
            hiz_right_o   <= 1'b0;
        end else if (wr_stb) begin
            case (wr_idx)
                SLOT_MODE: begin
                    en_left_o     <= wr_data[7];
                    en_right_o    <= wr_data[6];
                    sw_shutdown_o <= wr_data[0];
                end
                SLOT_VOL: begin
                    mute_left_o  <= wr_data[7];
                    mute_right_o <= wr_data[6];
                    volume_o     <= wr_data[5:1];
                end
                SLOT_HIZ: begin
                    hiz_left_o  <= wr_data[1];
                    hiz_right_o <= wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            SLOT_MODE: rd_data = {en_left_o, en_right_o, 4'b0000, thermal_i, sw_shutdown_o};
            SLOT_VOL:  rd_data = {mute_left_o, mute_right_o, volume_o, 1'b0};
            SLOT_HIZ:  rd_data = {6'b000000, hiz_left_o, hiz_right_o};
            SLOT_ID:   rd_data = ID_VALUE;
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/hpamp_bus_fsm.sv
`timescale 1ns/1ps
module hpamp_bus_fsm
    import hpamp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] rd_data,
    output logic       sda_drive_low,
    output logic [2:0] ptr_q,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic       srst_stb
);
    bus_state_t st, nxt;
    logic [7:0] sh;
    logic [2:0] cnt;
    logic       got8, ack_q, rw_q, gc_q;
    logic [7:0] rx_byte;
    logic       rx_state;

    assign rx_byte  = {sh[6:0], sda_s};
    assign rx_state = st inside {ST_ADDR, ST_PTR, ST_WDATA, ST_GCMD};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (stop_ev)       nxt = ST_IDLE;
        else if (start_ev) nxt = ST_ADDR;
        else begin
            unique case (st)
                ST_IDLE, ST_WAIT: nxt = st;
                ST_ADDR:      if (scl_fall && got8) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) nxt = !ack_q ? ST_WAIT :
                                                 gc_q   ? ST_GCMD :
                                                 rw_q   ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && got8) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nxt = ack_q ? ST_WDATA : ST_WAIT;
                ST_WDATA:     if (scl_fall && got8) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WAIT;
                ST_GCMD:      if (scl_fall && got8) nxt = ST_GCMD_ACK;
                ST_GCMD_ACK:  if (scl_fall) nxt = ST_WAIT;
                ST_RDATA:     if (scl_fall && got8) nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_rise && sda_s) nxt = ST_WAIT;
                              else if (scl_fall)     nxt = ST_RDATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // byte shifting, decode and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; cnt <= '0; got8 <= 1'b0; ack_q <= 1'b0;
            rw_q <= 1'b0; gc_q <= 1'b0; ptr_q <= '0;
            wr_stb <= 1'b0; wr_data <= '0; srst_stb <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            srst_stb <= 1'b0;
            if (start_ev || stop_ev) begin
                cnt  <= '0;
                got8 <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && !got8) begin
                    sh  <= rx_byte;
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) begin
                        got8 <= 1'b1;
                        case (st)
                            ST_ADDR: begin
                                rw_q <= rx_byte[0];
                                gc_q <= (rx_byte == GC_ADDR_BYTE);
                                if (rx_byte[7:1] == DEV_ADDR)
                                    ack_q <= rx_byte[0] ? slot_readable(ptr_q) : 1'b1;
                                else
                                    ack_q <= (rx_byte == GC_ADDR_BYTE);
                            end
                            ST_PTR: begin
                                ptr_q <= rx_byte[2:0];
                                ack_q <= slot_readable(rx_byte[2:0]);
                            end
                            ST_WDATA: begin
                                ack_q   <= slot_writable(ptr_q);
                                wr_stb  <= slot_writable(ptr_q);
                                wr_data <= rx_byte;
                            end
                            ST_GCMD: begin
                                ack_q <= (rx_byte == GC_RESET_CMD);
                                if (rx_byte == GC_RESET_CMD) begin
                                    srst_stb <= 1'b1;
                                    ptr_q    <= '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end else if (scl_fall && got8) begin
                    got8 <= 1'b0;
                    cnt  <= '0;
                end
            end else if (st == ST_RDATA) begin
                if (scl_rise && !got8) begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) got8 <= 1'b1;
                end else if (scl_fall) begin
                    if (got8) begin
                        got8 <= 1'b0;
                        cnt  <= '0;
                    end else begin
                        sh <= {sh[6:0], 1'b0};
                    end
                end
            end else if (scl_fall && ((st == ST_ADDR_ACK && ack_q && rw_q && !gc_q) ||
                                      st == ST_RD_ACK)) begin
                sh   <= rd_data;
                cnt  <= '0;
                got8 <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK, ST_GCMD_ACK: sda_drive_low = ack_q;
            ST_RDATA: sda_drive_low = !sh[7];
            default:  sda_drive_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/hpamp_i2c_regs.sv
`timescale 1ns/1ps
module hpamp_i2c_regs #(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter logic [7:0] ID_VALUE    = 8'hA3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       thermal_i,
    output logic       sda_drive_low_o,
    output logic       en_left_o,
    output logic       en_right_o,
    output logic       sw_shutdown_o,
    output logic       mute_left_o,
    output logic       mute_right_o,
    output logic [4:0] volume_o,
    output logic       hiz_left_o,
    output logic       hiz_right_o
);
    logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] rd_data, wr_data;
    logic [2:0] ptr;
    logic       wr_stb, srst_stb;

    hpamp_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    hpamp_bus_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .rd_data(rd_data), .sda_drive_low(sda_drive_low_o), .ptr_q(ptr),
        .wr_stb(wr_stb), .wr_data(wr_data), .srst_stb(srst_stb)
    );

    hpamp_ctrl_regs #(.ID_VALUE(ID_VALUE)) regs_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(srst_stb), .wr_stb(wr_stb),
        .wr_idx(ptr), .wr_data(wr_data), .rd_idx(ptr), .thermal_i(thermal_i),
        .rd_data(rd_data), .en_left_o(en_left_o), .en_right_o(en_right_o),
        .sw_shutdown_o(sw_shutdown_o), .mute_left_o(mute_left_o),
        .mute_right_o(mute_right_o), .volume_o(volume_o),
        .hiz_left_o(hiz_left_o), .hiz_right_o(hiz_right_o)
    );
endmodule

// File: rtl/hpamp_i2c_regs_chk.sv
`timescale 1ns/1ps
module hpamp_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_drive_low_o,
    input logic       wr_stb,
    input logic       srst_stb,
    input logic [2:0] wr_idx,
    input logic       en_left_o,
    input logic       en_right_o,
    input logic       sw_shutdown_o,
    input logic       mute_left_o,
    input logic       mute_right_o,
    input logic [4:0] volume_o,
    input logic       hiz_left_o,
    input logic       hiz_right_o
);
    // R10
    drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_i);

    // R3
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx >= 3'd1 && wr_idx <= 3'd3));

    // R8
    soft_reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_stb |=> (mute_left_o && mute_right_o && volume_o == 5'd0 &&
                      !en_left_o && !en_right_o && !sw_shutdown_o &&
                      !hiz_left_o && !hiz_right_o));

    // R4
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({en_left_o, en_right_o, sw_shutdown_o}) |->
            ($past(wr_stb && wr_idx == 3'd1) || $past(srst_stb)));

    // R5
    vol_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mute_left_o, mute_right_o, volume_o}) |->
            ($past(wr_stb && wr_idx == 3'd2) || $past(srst_stb)));

    // R6
    hiz_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({hiz_left_o, hiz_right_o}) |->
            ($past(wr_stb && wr_idx == 3'd3) || $past(srst_stb)));
endmodule

bind hpamp_i2c_regs hpamp_i2c_regs_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_low_o(sda_drive_low_o),
    .wr_stb(wr_stb), .srst_stb(srst_stb), .wr_idx(ptr),
    .en_left_o(en_left_o), .en_right_o(en_right_o), .sw_shutdown_o(sw_shutdown_o),
    .mute_left_o(mute_left_o), .mute_right_o(mute_right_o), .volume_o(volume_o),
    .hiz_left_o(hiz_left_o), .hiz_right_o(hiz_right_o)
);

// File: tb/hpamp_i2c_regs_tb_top.sv
`timescale 1ns/1ps
module hpamp_i2c_regs_tb_top;
    localparam int Q        = 8;
    localparam int WATCHDOG = 150000;
    localparam logic [7:0] ID_EXP = 8'hA3;

    // {pointer, data, expected readback, expected data ack}
    localparam logic [24:0] VEC [0:8] = '{
        {8'h01, 8'hFF, 8'hC1, 1'b1},
        {8'h01, 8'h3C, 8'h00, 1'b1},
        {8'h02, 8'hFF, 8'hFE, 1'b1},
        {8'h02, 8'h55, 8'h54, 1'b1},
        {8'h03, 8'hFF, 8'h03, 1'b1},
        {8'h03, 8'h01, 8'h01, 1'b1},
        {8'hF9, 8'h81, 8'h81, 1'b1},
        {8'h0C, 8'h12, ID_EXP, 1'b0},
        {8'h02, 8'h80, 8'h80, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_sda = 1'b1;
    logic thermal = 1'b0;
    logic drv, en_l, en_r, sws, mute_l, mute_r, hiz_l, hiz_r;
    logic [4:0] vol;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    int r10_viol = 0;
    logic drv_d = 1'b0;
    logic done = 1'b0;

    assign sda_line = host_sda & ~drv;

    always #10 clk = ~clk;

    hpamp_i2c_regs dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .thermal_i(thermal),
        .sda_drive_low_o(drv), .en_left_o(en_l), .en_right_o(en_r),
        .sw_shutdown_o(sws), .mute_left_o(mute_l), .mute_right_o(mute_r),
        .volume_o(vol), .hiz_left_o(hiz_l), .hiz_right_o(hiz_r)
    );

    always @(posedge clk) begin
        if (rst_n && drv && !drv_d && scl) r10_viol <= r10_viol + 1;
        drv_d <= drv;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; qwait(); scl = 1'b1; qwait();
        host_sda = 1'b0; qwait(); scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; qwait(); scl = 1'b1; qwait(); host_sda = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        host_sda = b; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        host_sda = 1'b1; qwait(); scl = 1'b1; qwait();
        acked = (sda_line == 1'b0);
        qwait(); scl = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(); scl = 1'b1; qwait(); b[i] = sda_line; qwait(); scl = 1'b0;
        end
        qwait(); host_sda = !host_ack; qwait(); scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic write_reg(input logic [7:0] p, input logic [7:0] d, input logic with_data,
                             output logic a_ptr, output logic a_dat);
        logic a_addr;
        bus_start(); send_byte(8'hC0, a_addr); send_byte(p, a_ptr);
        a_dat = 1'b0;
        if (with_data) send_byte(d, a_dat);
        bus_stop();
    endtask

    task automatic read_cur(output logic a_addr, output logic [7:0] d);
        bus_start(); send_byte(8'hC1, a_addr);
        d = 8'h00;
        if (a_addr) recv_byte(1'b0, d);
        bus_stop();
    endtask

    function automatic string tag_of(input logic [2:0] p);
        case (p)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual expired expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a, a2;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset values R4 R5 R6
        check("R4 reset en/sws", {en_l, en_r, sws}, 3'b000);
        check("R5 reset mutes", {mute_l, mute_r}, 2'b11);
        check("R5 reset volume", vol, 5'd0);
        check("R6 reset hiz", {hiz_l, hiz_r}, 2'b00);
        check("R10 idle release", drv, 1'b0);

        // R9: pointer 0 after reset, read address refused
        read_cur(a, d);
        check("R9 read with reserved pointer", a, 1'b0);

        // R1: wrong address
        bus_start(); send_byte(8'hC2, a); bus_stop();
        check("R1 foreign address nack", a, 1'b0);

        // R4: thermal flag
        thermal = 1'b1;
        write_reg(8'h01, 8'h00, 1'b0, a, a2);
        read_cur(a, d);
        check("R1 read address ack", a, 1'b1);
        check("R4 thermal bit", d, 8'h02);
        thermal = 1'b0;

        // vector table: R2 R4 R5 R6 R7
        for (int k = 0; k < 9; k++) begin
            logic [7:0] vp, vd, vr;
            logic va;
            {vp, vd, vr, va} = VEC[k];
            write_reg(vp, vd, 1'b1, a, a2);
            check({"R2 pointer ack ", tag_of(vp[2:0])}, a, 1'b1);
            check({tag_of(vp[2:0]), " data ack"}, a2, va);
            read_cur(a, d);
            check({tag_of(vp[2:0]), " readback"}, d, vr);
        end

        check("R4 outputs", {en_l, en_r, sws}, 3'b101);
        check("R5 outputs", {mute_l, mute_r, vol}, {2'b10, 5'd0});
        check("R6 outputs", {hiz_l, hiz_r}, 2'b01);

        // R3: reserved pointers
        foreach (VEC[k]) begin end
        for (int p = 0; p < 8; p++) begin
            if (p == 0 || p >= 5) begin
                write_reg(8'(p), 8'h00, 1'b0, a, a2);
                check("R3 reserved pointer nack", a, 1'b0);
            end
        end
        read_cur(a, d);
        check("R9 read after reserved pointer", a, 1'b0);

        // R12: second data byte refused
        bus_start(); send_byte(8'hC0, a); send_byte(8'h02, a);
        send_byte(8'h2C, a); send_byte(8'hFE, a2); bus_stop();
        check("R12 first byte ack", a, 1'b1);
        check("R12 second byte nack", a2, 1'b0);
        check("R12 volume kept", {mute_l, mute_r, vol}, {2'b00, 5'h16});

        // R9: repeated start, repeated bytes, NACK release
        bus_start(); send_byte(8'hC0, a); send_byte(8'h02, a);
        bus_start(); send_byte(8'hC1, a);
        recv_byte(1'b1, d); check("R9 first byte", d, 8'h2C);
        recv_byte(1'b1, d); check("R9 second byte", d, 8'h2C);
        recv_byte(1'b0, d); check("R9 last byte", d, 8'h2C);
        check("R9 released after nack", drv, 1'b0);
        bus_stop();

        // R11: aborts mid-byte
        bus_start(); send_byte(8'hC0, a); send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start(); bus_stop();
        check("R11 start abort", {mute_l, mute_r, vol}, {2'b00, 5'h16});
        bus_start(); send_byte(8'hC0, a); send_byte(8'h03, a);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_stop();
        check("R11 stop abort", {hiz_l, hiz_r}, 2'b01);

        // R8: general call
        bus_start(); send_byte(8'h00, a); send_byte(8'h05, a2); bus_stop();
        check("R8 general call ack", a, 1'b1);
        check("R8 other command nack", a2, 1'b0);
        check("R8 other command no effect", {mute_l, mute_r, vol}, {2'b00, 5'h16});
        bus_start(); send_byte(8'h00, a); send_byte(8'h06, a2); bus_stop();
        check("R8 reset command ack", a2, 1'b1);
        check("R8 restored", {en_l, en_r, sws, mute_l, mute_r, vol, hiz_l, hiz_r},
              {3'b000, 2'b11, 5'd0, 2'b00});
        read_cur(a, d);
        check("R8 pointer restored", a, 1'b0);

        check("R10 drive only while SCL low", r10_viol, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule